// File: doc/BRIEF.md
# SPI NOR Flash Controller

This block connects a SoC bus to a single serial NOR flash device over a four-wire SPI link. It has two ports. A small register port holds the configuration. A flash window port carries the data accesses. Every window access stalls on a valid/ready handshake until the serial shift behind it has finished.

Software can reach the flash in two ways. In pass-through (user) mode, software drives chip select through a control bit. Each window access then moves raw bytes on the link, and consecutive accesses continue the same stream. In the command modes, one window access becomes a complete flash transaction: a stored opcode, then the access address with its most significant byte first (3 or 4 bytes), an optional dummy byte, and finally the data bytes. Chip select is handled automatically and is released afterwards.

Top module: `spi_flash_ctl`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, and all three registers read 0.
- R2: The registers respond at these byte offsets, and unimplemented bits read 0.
  - 0x00: bit 16 is the window-write enable.
  - 0x04: bit 0 selects 4-byte addressing.
  - 0x10: bits [1:0] are the mode (0 read, 1 fast read, 2 write, 3 pass-through), bit 2 is the chip-select stop bit, and bits [23:16] are the opcode.
- R3: While no command transaction is active, spi_cs_n equals the stop bit in pass-through mode and is 1 in every other mode.
- R4: A pass-through window write sends 1, 2 or 4 bytes for win_size 0, 1 or 2. Bytes go out from byte lane 0 upward, each with its MSB first, and chip select stays low across all accesses.
- R5: A pass-through window read clocks in 1, 2 or 4 bytes and places them in lanes 0 upward. Successive reads continue the same chip-select frame.
- R6: In read mode, a window read sends the opcode, then the address MSB first (3 bytes, or 4 when the addressing bit is set), then reads the data. All of this happens in one chip-select frame.
- R7: Fast read mode inserts exactly one dummy byte (8 clocks, data 0x00) between the address and the data.
- R8: In write mode with the enable bit set, a window write sends the opcode, the address and then the data bytes from lane 0 upward, all in one frame.
- R9: Some accesses are acknowledged without any link activity:
  - a window write in write mode while the enable bit is clear;
  - a window write in either read mode;
  - a window read in write mode, which returns 0.
- R10: The link runs in SPI mode 0. spi_sclk idles low. Each high phase lasts HALF_DIV clocks. spi_mosi changes only while spi_sclk is low.
- R11: After a command transaction, spi_cs_n stays high for at least 2*HALF_DIV clocks before the next frame can start.
- R12: A mode or opcode register write made during a command transaction does not affect that transaction. It applies from the next access onward.
- R13: win_ready is a single-cycle pulse, given exactly once for each accepted window access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | Register write when 1 |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| win_valid | input | 1 | Window access request, held until win_ready |
| win_write | input | 1 | Window write when 1 |
| win_addr | input | 32 | Window byte offset, used as the flash address |
| win_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| win_wdata | input | 32 | Window write data, lane 0 first on the link |
| win_ready | output | 1 | Completion pulse |
| win_rdata | output | 32 | Window read data, valid with win_ready |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with HALF_DIV = 2, so one byte takes 32 clocks. At that speed the bench can afford a full sweep: both read modes, both address widths, all three access sizes and two addresses, each producing one complete transaction. A behavioural flash model on the link logs every byte sent and answers each byte position in a frame with a value computed from that position. This lets the bench predict every opcode, address byte, dummy byte and returned lane arithmetically. The small divider also makes the high-phase length and the chip-select release gap short enough to measure exactly.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

  localparam int REG_AW = 5;
  localparam int WORD_W = 32;

  localparam logic [REG_AW-1:0] OFF_CONF  = 5'h00;
  localparam logic [REG_AW-1:0] OFF_CSCTL = 5'h04;
  localparam logic [REG_AW-1:0] OFF_CTRL  = 5'h10;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_FREAD = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_USER  = 2'd3
  } fmode_e;

  typedef struct packed {
    logic       win_wr_en;
    logic       addr4;
    fmode_e     mode;
    logic       cs_stop;
    logic [7:0] opcode;
  } fcfg_t;

  // bytes moved by one window access
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // header byte idx of a command frame: opcode, address MSB first, then dummy
  function automatic logic [7:0] hdr_byte(input logic [7:0] op, input logic [31:0] addr,
                                          input logic [2:0] alen, input logic [2:0] idx);
    logic [5:0] sh;
    if (idx == 3'd0) return op;
    if (idx <= alen) begin
      sh = {3'(alen - idx), 3'b000};
      return 8'(addr >> sh);
    end
    return 8'h00;
  endfunction

  function automatic logic [7:0] lane(input logic [WORD_W-1:0] w, input logic [1:0] k);
    return w[k*8 +: 8];
  endfunction

endpackage

// File: rtl/spi_flash_regs.sv
module spi_flash_regs
  import spi_flash_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_valid,
  input  logic                reg_write,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output fcfg_t               cfg
);

  logic       wen_q;
  logic       a4_q;
  logic [1:0] mode_q;
  logic       stop_q;
  logic [7:0] op_q;
  logic       unused_wdata;

  assign unused_wdata = ^{reg_wdata[31:24], reg_wdata[15:3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q  <= 1'b0;
      a4_q   <= 1'b0;
      mode_q <= 2'd0;
      stop_q <= 1'b0;
      op_q   <= 8'h00;
    end else if (reg_valid && reg_write) begin
      case (reg_addr)
        OFF_CONF:  wen_q <= reg_wdata[16];
        OFF_CSCTL: a4_q  <= reg_wdata[0];
        OFF_CTRL: begin
          mode_q <= reg_wdata[1:0];
          stop_q <= reg_wdata[2];
          op_q   <= reg_wdata[23:16];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_CONF:  reg_rdata[16] = wen_q;
      OFF_CSCTL: reg_rdata[0]  = a4_q;
      OFF_CTRL:  reg_rdata     = {8'h00, op_q, 13'd0, stop_q, mode_q};
      default: ;
    endcase
  end

  assign cfg = '{win_wr_en: wen_q, addr4: a4_q, mode: fmode_e'(mode_q),
                 cs_stop: stop_q, opcode: op_q};

endmodule

// File: rtl/spi_flash_shifter.sv
module spi_flash_shifter #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi,
  output logic       rise_evt,
  output logic       fall_evt
);

  localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam logic [CW-1:0] CNT_END = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q;
  logic [7:0]    rx_q;
  logic          phase_q;
  logic          busy_q;
  logic          done_q;
  logic          tick;

  assign tick     = busy_q && (cnt_q == CNT_END);
  assign rise_evt = tick && !phase_q;
  assign fall_evt = tick && phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      bit_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      phase_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          tx_q    <= tx_byte;
          cnt_q   <= '0;
          bit_q   <= '0;
          phase_q <= 1'b0;
        end
      end else if (tick) begin
        cnt_q <= '0;
        if (rise_evt) begin
          phase_q <= 1'b1;
          rx_q    <= {rx_q[6:0], miso};
        end else begin
          phase_q <= 1'b0;
          tx_q    <= {tx_q[6:0], 1'b0};
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
          end
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign sclk    = phase_q;
  assign mosi    = busy_q & tx_q[7];

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import spi_flash_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fcfg_t             cfg,
  input  logic              win_valid,
  input  logic              win_write,
  input  logic [WORD_W-1:0] win_addr,
  input  logic [1:0]        win_size,
  input  logic [WORD_W-1:0] win_wdata,
  output logic              win_ready,
  output logic [WORD_W-1:0] win_rdata,
  output logic              sh_start,
  output logic [7:0]        sh_tx,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx,
  output logic              cs_n,
  output logic              cmd_active,
  output logic              ign_evt
);

  localparam int GAP_CYC = 2 * HALF_DIV;
  localparam int GW      = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GAP_END = GW'(GAP_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_WAIT, S_GAP, S_RESP} seq_e;

  seq_e              st_q;
  logic              cmd_q, wr_q;
  logic [7:0]        op_q;
  logic [WORD_W-1:0] addr_q, wdata_q, rdata_q;
  logic [2:0]        alen_q;
  logic [3:0]        hdr_q, tot_q, idx_q;
  logic [GW-1:0]     gap_q;

  // request decode against the live configuration
  logic       is_user, do_cmd, is_fast;
  logic [2:0] alen_n;
  logic [3:0] hdr_n;
  logic [1:0] dlane;

  assign is_user = (cfg.mode == MODE_USER);
  assign is_fast = !win_write && (cfg.mode == MODE_FREAD);
  assign do_cmd  = !is_user &&
                   ((win_write && cfg.mode == MODE_WRITE && cfg.win_wr_en) ||
                    (!win_write && (cfg.mode == MODE_READ || cfg.mode == MODE_FREAD)));
  assign alen_n  = cfg.addr4 ? 3'd4 : 3'd3;
  assign hdr_n   = is_user ? 4'd0 : 4'd1 + {1'b0, alen_n} + {3'd0, is_fast};
  assign ign_evt = (st_q == S_IDLE) && win_valid && !is_user && !do_cmd;
  assign dlane   = 2'(idx_q - hdr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cmd_q   <= 1'b0;
      wr_q    <= 1'b0;
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      alen_q  <= '0;
      hdr_q   <= '0;
      tot_q   <= '0;
      idx_q   <= '0;
      gap_q   <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (win_valid) begin
          rdata_q <= '0;
          if (is_user || do_cmd) begin
            st_q    <= S_LOAD;
            cmd_q   <= do_cmd;
            wr_q    <= win_write;
            op_q    <= cfg.opcode;
            addr_q  <= win_addr;
            wdata_q <= win_wdata;
            alen_q  <= alen_n;
            hdr_q   <= hdr_n;
            tot_q   <= hdr_n + {1'b0, size_bytes(win_size)};
            idx_q   <= '0;
          end else begin
            st_q <= S_RESP;
          end
        end
        S_LOAD: st_q <= S_WAIT;
        S_WAIT: if (sh_done) begin
          if (!wr_q && idx_q >= hdr_q) rdata_q[dlane*8 +: 8] <= sh_rx;
          if (idx_q + 4'd1 == tot_q) begin
            st_q  <= cmd_q ? S_GAP : S_RESP;
            gap_q <= '0;
          end else begin
            idx_q <= idx_q + 4'd1;
            st_q  <= S_LOAD;
          end
        end
        S_GAP: begin
          gap_q <= gap_q + 1'b1;
          if (gap_q == GAP_END) st_q <= S_RESP;
        end
        S_RESP:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign sh_start = (st_q == S_LOAD);
  always_comb begin
    if (idx_q < hdr_q)  sh_tx = hdr_byte(op_q, addr_q, alen_q, 3'(idx_q));
    else if (wr_q)      sh_tx = lane(wdata_q, dlane);
    else                sh_tx = 8'h00;
  end

  assign cmd_active = cmd_q && (st_q == S_LOAD || st_q == S_WAIT);
  assign cs_n = cmd_active      ? 1'b0 :
                (st_q == S_GAP) ? 1'b1 :
                is_user         ? cfg.cs_stop : 1'b1;

  assign win_ready = (st_q == S_RESP);
  assign win_rdata = rdata_q;

endmodule

// File: rtl/spi_flash_ctl.sv
module spi_flash_ctl
  import spi_flash_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              win_valid,
  input  logic              win_write,
  input  logic [WORD_W-1:0] win_addr,
  input  logic [1:0]        win_size,
  input  logic [WORD_W-1:0] win_wdata,
  output logic              win_ready,
  output logic [WORD_W-1:0] win_rdata,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  fcfg_t      cfg;
  logic       sh_start, sh_done, sh_busy;
  logic [7:0] sh_tx, sh_rx;
  logic       rise_evt, fall_evt;
  logic       cmd_active, ign_evt;

  spi_flash_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg(cfg)
  );

  spi_flash_seq #(.HALF_DIV(HALF_DIV)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg(cfg),
    .win_valid(win_valid), .win_write(win_write), .win_addr(win_addr),
    .win_size(win_size), .win_wdata(win_wdata), .win_ready(win_ready),
    .win_rdata(win_rdata), .sh_start(sh_start), .sh_tx(sh_tx),
    .sh_done(sh_done), .sh_rx(sh_rx), .cs_n(spi_cs_n),
    .cmd_active(cmd_active), .ign_evt(ign_evt)
  );

  spi_flash_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx), .miso(spi_miso),
    .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx), .sclk(spi_sclk),
    .mosi(spi_mosi), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

endmodule

// File: rtl/spi_flash_ctl_chk.sv
module spi_flash_ctl_chk #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_cs_n,
  input logic win_valid,
  input logic win_ready,
  input logic sh_busy,
  input logic cmd_active,
  input logic ign_evt,
  input logic rise_evt,
  input logic fall_evt
);

  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_cnt <= '0;
    else if (spi_sclk) hi_cnt <= hi_cnt + 16'd1;
    else               hi_cnt <= '0;
  end

  assert_sclk_rest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_busy |-> !spi_sclk);
  assert_mosi_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));
  assert_half_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sclk) |-> (hi_cnt == 16'(HALF_DIV)));
  assert_edge_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> spi_sclk);
  assert_fall_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !spi_sclk);
  assert_ready_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |=> !win_ready);
  assert_ready_valid_R13: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |-> win_valid);
  assert_cs_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_active |-> !spi_cs_n);
  assert_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ign_evt |=> (win_ready && !sh_busy));

endmodule

bind spi_flash_ctl spi_flash_ctl_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
  .spi_cs_n(spi_cs_n), .win_valid(win_valid), .win_ready(win_ready),
  .sh_busy(sh_busy), .cmd_active(cmd_active), .ign_evt(ign_evt),
  .rise_evt(rise_evt), .fall_evt(fall_evt)
);

// File: tb/spi_flash_ctl_tb.sv
module spi_flash_ctl_tb;

  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 0, reg_write = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        win_valid = 0, win_write = 0;
  logic [31:0] win_addr = 0, win_wdata = 0, win_rdata;
  logic [1:0]  win_size = 0;
  logic        win_ready, spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  always #10 clk = ~clk;

  spi_flash_ctl #(.HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .win_valid(win_valid), .win_write(win_write), .win_addr(win_addr),
    .win_size(win_size), .win_wdata(win_wdata), .win_ready(win_ready),
    .win_rdata(win_rdata), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  function automatic logic [7:0] resp_b(input int i);
    logic [7:0] t;
    t = 8'(i * 29);
    return t ^ 8'h5A;
  endfunction

  logic [7:0] log_mem [0:1023];
  int         log_n = 0, frames = 0, bidx = 0, bit_i = 0;
  logic [7:0] sh_in = 0;
  logic [7:0] cur_resp;

  assign cur_resp = resp_b(bidx);
  assign spi_miso = cur_resp[3'(7 - bit_i)];

  always @(posedge spi_sclk or negedge spi_cs_n) begin
    if (spi_sclk) begin
      if (spi_cs_n === 1'b0) begin
        sh_in = {sh_in[6:0], spi_mosi};
        if (bit_i == 7) begin
          log_mem[log_n % 1024] = sh_in;
          log_n++;
          bidx++;
          bit_i = 0;
        end else bit_i++;
      end
    end else begin
      bidx = 0;
      bit_i = 0;
    end
  end

  always @(posedge spi_cs_n) frames++;

  // ---------------- link monitor ----------------
  int   rdy_cnt = 0, viol = 0, hi_run = 0, cs_hi_run = 0, last_gap = 0, acc_cnt = 0;
  logic p_sclk = 0, p_mosi = 0, p_cs = 1;

  always @(negedge clk) if (rst_n) begin
    if (win_ready) rdy_cnt++;
    if (spi_sclk && p_sclk && spi_mosi !== p_mosi) viol++;
    if (spi_sclk) hi_run++;
    else begin
      if (p_sclk && hi_run != HALF) viol++;
      hi_run = 0;
    end
    if (spi_cs_n) cs_hi_run++;
    else begin
      if (p_cs) last_gap = cs_hi_run;
      cs_hi_run = 0;
    end
    p_sclk = spi_sclk; p_mosi = spi_mosi; p_cs = spi_cs_n;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R13 watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- bus tasks ----------------
  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic win(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    win_valid = 1; win_write = wr; win_addr = a; win_size = sz; win_wdata = wd;
    acc_cnt++;
    do @(negedge clk); while (!win_ready);
    rd = win_rdata;
    @(posedge clk);
    #1 win_valid = 0;
  endtask

  function automatic int nb(input logic [1:0] sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  logic [31:0] rd, exp;
  int base, fr0;
  logic [31:0] pats [0:2] = '{32'h01234567, 32'hA5C3F00F, 32'h8001FE7E};
  logic [31:0] addrs [0:1] = '{32'h0014_0000, 32'h12AB_CDEF};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cs_n", {31'd0, spi_cs_n}, 32'd1);
    chk("R1 sclk", {31'd0, spi_sclk}, 32'd0);
    reg_rd(5'h00, rd); chk("R1 conf", rd, 0);
    reg_rd(5'h04, rd); chk("R1 csctl", rd, 0);
    reg_rd(5'h10, rd); chk("R1 ctrl", rd, 0);

    // R2 register fields
    reg_wr(5'h00, 32'hFFFF_FFFF); reg_rd(5'h00, rd); chk("R2 conf", rd, 32'h0001_0000);
    reg_wr(5'h04, 32'hFFFF_FFFF); reg_rd(5'h04, rd); chk("R2 csctl", rd, 32'h1);
    reg_wr(5'h10, 32'hFFFF_FFFF); reg_rd(5'h10, rd); chk("R2 ctrl", rd, 32'h00FF_0007);
    reg_rd(5'h08, rd); chk("R2 hole", rd, 0);
    reg_wr(5'h00, 0); reg_wr(5'h04, 0);

    // R3 chip select in pass-through mode
    reg_wr(5'h10, 32'h7); #1 chk("R3 stop", {31'd0, spi_cs_n}, 1);
    reg_wr(5'h10, 32'h0); #1 chk("R3 other mode", {31'd0, spi_cs_n}, 1);
    reg_wr(5'h10, 32'h7);
    reg_wr(5'h10, 32'h3); #1 chk("R3 low", {31'd0, spi_cs_n}, 0);

    // R4 pass-through writes, all sizes and patterns, one frame
    fr0 = frames; base = log_n;
    for (int s = 0; s < 3; s++)
      for (int p = 0; p < 3; p++) begin
        int b0;
        b0 = log_n;
        win(1, 32'h0, 2'(s), pats[p], rd);
        chk("R4 count", 32'(log_n - b0), 32'(nb(2'(s))));
        for (int k = 0; k < nb(2'(s)); k++)
          chk("R4 byte", {24'd0, log_mem[(b0 + k) % 1024]}, {24'd0, pats[p][k*8 +: 8]});
      end
    chk("R4 one frame", 32'(frames - fr0), 0);
    reg_wr(5'h10, 32'h7);
    chk("R4 frame end", 32'(frames - fr0), 1);

    // R5 pass-through reads continue the stream
    reg_wr(5'h10, 32'h3);
    win(0, 32'h0, 2'd0, 0, rd);
    chk("R5 first", rd, {24'd0, resp_b(0)});
    win(0, 32'h0, 2'd2, 0, rd);
    chk("R5 cont", rd, {resp_b(4), resp_b(3), resp_b(2), resp_b(1)});
    win(0, 32'h0, 2'd1, 0, rd);
    chk("R5 half", rd, {16'd0, resp_b(6), resp_b(5)});
    reg_wr(5'h10, 32'h7);

    // R6/R7 command reads, full sweep
    for (int m = 0; m < 2; m++)
      for (int a4 = 0; a4 < 2; a4++)
        for (int s = 0; s < 3; s++)
          for (int ai = 0; ai < 2; ai++) begin
            int alen, hdr, n;
            logic [7:0] op;
            op = 8'h03 + 8'(m * 8);
            alen = a4 ? 4 : 3;
            hdr = 1 + alen + m;
            n = nb(2'(s));
            reg_wr(5'h04, 32'(a4));
            reg_wr(5'h10, {8'h00, op, 16'(m)});
            base = log_n; fr0 = frames;
            win(0, addrs[ai], 2'(s), 0, rd);
            chk("R6 length", 32'(log_n - base), 32'(hdr + n));
            chk("R6 opcode", {24'd0, log_mem[base % 1024]}, {24'd0, op});
            for (int k = 1; k <= alen; k++)
              chk("R6 address", {24'd0, log_mem[(base + k) % 1024]},
                  {24'd0, 8'(addrs[ai] >> ((alen - k) * 8))});
            if (m == 1) chk("R7 dummy", {24'd0, log_mem[(base + alen + 1) % 1024]}, 0);
            exp = 0;
            for (int k = 0; k < n; k++) exp[k*8 +: 8] = resp_b(hdr + k);
            chk(m ? "R7 data" : "R6 data", rd, exp);
            chk("R6 frame", 32'(frames - fr0), 1);
            chk("R6 cs idle", {31'd0, spi_cs_n}, 1);
          end

    // R11 release gap between back-to-back command reads
    reg_wr(5'h04, 0); reg_wr(5'h10, 32'h0003_0000);
    win(0, 32'h100, 2'd0, 0, rd);
    win(0, 32'h200, 2'd0, 0, rd);
    chk("R11 gap", {31'd0, (last_gap >= 2 * HALF)}, 1);

    // R8 command writes with enable
    reg_wr(5'h00, 32'h0001_0000);
    for (int a4 = 0; a4 < 2; a4++) begin
      int alen;
      alen = a4 ? 4 : 3;
      reg_wr(5'h04, 32'(a4));
      reg_wr(5'h10, 32'h0002_0002);
      base = log_n;
      win(1, 32'h0150_0040, 2'd2, 32'hA1B2C3D4, rd);
      chk("R8 length", 32'(log_n - base), 32'(1 + alen + 4));
      chk("R8 opcode", {24'd0, log_mem[base % 1024]}, 32'h02);
      for (int k = 1; k <= alen; k++)
        chk("R8 address", {24'd0, log_mem[(base + k) % 1024]},
            {24'd0, 8'(32'h0150_0040 >> ((alen - k) * 8))});
      for (int k = 0; k < 4; k++)
        chk("R8 data", {24'd0, log_mem[(base + 1 + alen + k) % 1024]},
            {24'd0, 8'(32'hA1B2C3D4 >> (k * 8))});
    end

    // R9 ignored accesses
    reg_wr(5'h00, 0);
    base = log_n; fr0 = frames;
    win(1, 32'h40, 2'd2, 32'h1111_2222, rd);
    chk("R9 disabled write", 32'(log_n - base), 0);
    win(0, 32'h40, 2'd2, 0, rd);
    chk("R9 read in write mode", rd, 0);
    reg_wr(5'h00, 32'h0001_0000);
    reg_wr(5'h10, 32'h0003_0000);
    win(1, 32'h40, 2'd0, 32'h77, rd);
    chk("R9 write in read mode", 32'(log_n - base), 0);
    chk("R9 no frame", 32'(frames - fr0), 0);

    // R12 register change during a transaction
    reg_wr(5'h04, 0);
    reg_wr(5'h10, 32'h0003_0000);
    base = log_n;
    fork
      win(0, 32'h80, 2'd0, 0, rd);
      begin
        repeat (20) @(negedge clk);
        reg_wr(5'h10, 32'h000B_0001);
      end
    join
    chk("R12 old opcode", {24'd0, log_mem[base % 1024]}, 32'h03);
    chk("R12 old length", 32'(log_n - base), 5);
    base = log_n;
    win(0, 32'h80, 2'd0, 0, rd);
    chk("R12 new opcode", {24'd0, log_mem[base % 1024]}, 32'h0B);
    chk("R12 new length", 32'(log_n - base), 6);

    // R10 / R13 link and handshake summary
    repeat (4) @(negedge clk);
    chk("R10 timing violations", 32'(viol), 0);
    chk("R10 sclk idle", {31'd0, spi_sclk}, 0);
    chk("R13 ready count", 32'(rdy_cnt), 32'(acc_cnt));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule